// File: doc/BRIEF.md
# Serial Preamble and Start-Delimiter Checker

This block watches a one-bit serial Ethernet receive stream, one bit per receive clock. A frame is framed by a data-valid strobe. The block decides whether the frame opens with an acceptable preamble and start delimiter. The leading bit times of every frame are treated as settling time and are not examined. A short window that follows must carry strictly alternating bits. After that window the block waits for two consecutive ones, which close the header.

Once the header closes, the block strips every header bit and passes each later bit of the frame to its output with a valid qualifier. It marks the first passed bit with a one-cycle start pulse. A header that breaks the rules raises a one-cycle abort pulse, and the rest of that frame is discarded. The block arms again only after data-valid has gone low. Byte assembly, address filtering and CRC checking happen further down the receive path.

Top module: `psfd_checker`

## Requirements
- R1: After a synchronous reset, out_valid, out_bit, frame_start and frame_abort are all 0.
- R2: A frame is recognised only when rx_dv rises while enable is 1. The bit sampled in that rising cycle is bit time 1. If rx_dv is already high when enable rises, nothing is output until rx_dv has been low for a cycle.
- R3: Bit times 1 to 16 have no effect, whatever their values. This includes a bit 16 equal to bit 17.
- R4: Any two equal adjacent bits where both bits fall in bit times 17 to 21 give frame_abort = 1 for one cycle, and the remainder of the frame is dropped.
- R5: From bit time 22 onward, the first pair of adjacent ones whose later bit is at time 22 or after completes the header. Every bit sampled after that pair while rx_dv and enable stay 1 appears on out_bit with out_valid = 1, one clock after it is sampled. No header bit is ever output.
- R6: frame_start is 1 for exactly the cycle in which the first forwarded bit is on the output, and 0 at all other times.
- R7: From bit time 22 onward, an adjacent pair of zeros seen before the delimiter pair (the pair of bits 21 and 22 included) gives frame_abort = 1 for one cycle, one clock after the second zero is sampled.
- R8: After an abort, the block gives no output until rx_dv has gone low. The next rising edge of rx_dv starts a fresh check.
- R9: If rx_dv falls before the delimiter is found, the frame is dropped with no output pulse and no abort.
- R10: While enable is 0 all outputs stay 0 one clock later. Lowering enable in the middle of a frame drops that frame without an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable |
| rx_dv | input | 1 | Receive data-valid strobe |
| rx_bit | input | 1 | Serial receive data bit |
| out_valid | output | 1 | A forwarded frame bit is on out_bit |
| out_bit | output | 1 | Forwarded frame bit |
| frame_start | output | 1 | Marks the first forwarded bit of a frame |
| frame_abort | output | 1 | One-cycle pulse when a header is rejected |

## Verification
The main check is tried with several stimuli:
- a clean header with a long hunting stretch;
- a delimiter at the earliest legal time, bits 21 and 22;
- settling bits that are all ones, with bit 16 equal to bit 17;
- a repeated bit inside the alternation window;
- a zero pair during the hunt;
- a zero pair at bits 21 and 22.

These stimuli separate an off-by-one settling window, an alternation window of the wrong length, and a delimiter or reject rule applied too early or too late. Further runs cover the framing rules: data-valid dropping during the hunt, enable held low, enable rising mid-frame, enable falling mid-payload, and a frame that follows an aborted one after a single idle cycle. Each run is compared bit by bit against a behavioural model, and its totals of start pulses, aborts and forwarded bits are checked against counts worked out by hand.

// File: rtl/psfd_pkg.sv
package psfd_pkg;

    // Fixed header windows, in bit times counted from the data-valid rise.
    localparam int unsigned SETTLE_BITS = 16;
    localparam int unsigned ALT_END_BIT = 21;
    localparam int unsigned IDX_BITS    = $clog2(ALT_END_BIT + 1) + 1;

    typedef logic [IDX_BITS-1:0] bit_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ALTERNATE,
        ST_HUNT,
        ST_PASS,
        ST_DROP
    } hdr_state_e;

    // One bit travelling toward the output stage.
    typedef struct packed {
        logic valid;
        logic data;
        logic first;
    } fwd_beat_t;

    // Verdict on the current header bit.
    typedef struct packed {
        logic delim;
        logic reject;
    } hdr_verdict_t;

    function automatic logic repeats(input logic prev_b, input logic cur_b);
        return prev_b == cur_b;
    endfunction

    function automatic hdr_verdict_t judge_hunt(input logic prev_b, input logic cur_b);
        hdr_verdict_t v;
        v.delim  = repeats(prev_b, cur_b) &&  cur_b;
        v.reject = repeats(prev_b, cur_b) && !cur_b;
        return v;
    endfunction

endpackage

// File: rtl/psfd_frame_gate.sv
module psfd_frame_gate (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rx_dv,
    output logic start_o,
    output logic live_o
);
    logic dv_q;

    always_ff @(posedge clk) begin
        if (rst) dv_q <= 1'b1;   // no frame may begin in the first cycle out of reset mid-strobe
        else     dv_q <= rx_dv;
    end

    always_comb begin
        live_o  = rx_dv && enable;
        start_o = rx_dv && !dv_q && enable;
    end
endmodule

// File: rtl/psfd_bit_index.sv
module psfd_bit_index #(
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned IDX_MAX = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             live_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] SAT = IDX_W'(IDX_MAX);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] idx_q;

    // Index of the bit sampled in this cycle, 1-based, saturating.
    always_comb begin
        if (start_i)           idx_o = ONE;
        else if (idx_q >= SAT) idx_o = SAT;
        else                   idx_o = idx_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (live_i) idx_q <= idx_o;
        else             idx_q <= '0;
    end
endmodule

// File: rtl/psfd_header_fsm.sv
module psfd_header_fsm
    import psfd_pkg::*;
#(
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned SETTLE_N  = 16,
    parameter int unsigned ALT_LAST  = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             live_i,
    input  logic             bit_i,
    input  logic [IDX_W-1:0] idx_i,
    output fwd_beat_t        beat_o,
    output logic             abort_o
);
    localparam logic [IDX_W-1:0] SETTLE_END = IDX_W'(SETTLE_N);
    localparam logic [IDX_W-1:0] ALT_FIRST  = IDX_W'(SETTLE_N + 1);
    localparam logic [IDX_W-1:0] ALT_END    = IDX_W'(ALT_LAST);

    hdr_state_e   state_q, state_d;
    logic         prev_q;
    logic         first_q, first_d;
    hdr_verdict_t hunt_v;

    always_comb hunt_v = judge_hunt(prev_q, bit_i);

    always_comb begin
        state_d = state_q;
        first_d = first_q;
        abort_o = 1'b0;
        beat_o  = '0;
        if (!live_i) begin
            state_d = ST_IDLE;
            first_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) state_d = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (idx_i >= SETTLE_END) state_d = ST_ALTERNATE;
                end
                ST_ALTERNATE: begin
                    if (idx_i > ALT_FIRST && repeats(prev_q, bit_i)) begin
                        abort_o = 1'b1;
                        state_d = ST_DROP;
                    end else if (idx_i >= ALT_END) begin
                        state_d = ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (hunt_v.delim) begin
                        state_d = ST_PASS;
                        first_d = 1'b1;
                    end else if (hunt_v.reject) begin
                        abort_o = 1'b1;
                        state_d = ST_DROP;
                    end
                end
                ST_PASS: begin
                    beat_o.valid = 1'b1;
                    beat_o.data  = bit_i;
                    beat_o.first = first_q;
                    first_d      = 1'b0;
                end
                ST_DROP: state_d = ST_DROP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prev_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= bit_i;
            first_q <= first_d;
        end
    end

    // R4: the alternation state is only ever entered for bit times 17..21
    p_alt_window_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALTERNATE && live_i && !start_i) |-> (idx_i >= ALT_FIRST && idx_i <= ALT_END));

    // R3: nothing is rejected during the settling bits
    p_settle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> !abort_o && !beat_o.valid);
endmodule

// File: rtl/psfd_out_stage.sv
module psfd_out_stage
    import psfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fwd_beat_t beat_i,
    input  logic      abort_i,
    output logic      out_valid_o,
    output logic      out_bit_o,
    output logic      frame_start_o,
    output logic      frame_abort_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o   <= 1'b0;
            out_bit_o     <= 1'b0;
            frame_start_o <= 1'b0;
            frame_abort_o <= 1'b0;
        end else begin
            out_valid_o   <= beat_i.valid;
            out_bit_o     <= beat_i.valid && beat_i.data;
            frame_start_o <= beat_i.valid && beat_i.first;
            frame_abort_o <= abort_i;
        end
    end

    // R6: the start marker always rides on a forwarded bit
    p_start_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> out_valid_o);

    // R7: an abort never coincides with forwarded data
    p_abort_excl_r7: assert property (@(posedge clk) disable iff (rst)
        frame_abort_o |-> !out_valid_o);
endmodule

// File: rtl/psfd_checker.sv
module psfd_checker
    import psfd_pkg::*;
#(
    parameter int unsigned SETTLE_N = SETTLE_BITS,
    parameter int unsigned ALT_LAST = ALT_END_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rx_dv,
    input  logic rx_bit,
    output logic out_valid,
    output logic out_bit,
    output logic frame_start,
    output logic frame_abort
);
    localparam int unsigned IDX_W   = $clog2(ALT_LAST + 1) + 1;
    localparam int unsigned IDX_MAX = ALT_LAST + 1;

    logic             start_w, live_w, abort_w;
    logic [IDX_W-1:0] idx_w;
    fwd_beat_t        beat_w;

    psfd_frame_gate u_gate (
        .clk(clk), .rst(rst), .enable(enable), .rx_dv(rx_dv),
        .start_o(start_w), .live_o(live_w)
    );

    psfd_bit_index #(.IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) u_index (
        .clk(clk), .rst(rst), .start_i(start_w), .live_i(live_w), .idx_o(idx_w)
    );

    psfd_header_fsm #(.IDX_W(IDX_W), .SETTLE_N(SETTLE_N), .ALT_LAST(ALT_LAST)) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_w), .live_i(live_w), .bit_i(rx_bit),
        .idx_i(idx_w), .beat_o(beat_w), .abort_o(abort_w)
    );

    psfd_out_stage u_out (
        .clk(clk), .rst(rst), .beat_i(beat_w), .abort_i(abort_w),
        .out_valid_o(out_valid), .out_bit_o(out_bit),
        .frame_start_o(frame_start), .frame_abort_o(frame_abort)
    );

    // R8: a rejected frame stays silent on the following cycle
    p_drop_silent_r8: assert property (@(posedge clk) disable iff (rst)
        frame_abort |=> !out_valid && !frame_abort);

    // R10: disabling quiets every output one clock later
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !out_valid && !frame_start && !frame_abort);

    // R6: the first bit of each forwarded run carries the start marker
    p_first_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> frame_start);
endmodule

// File: tb/psfd_checker_bench.sv
module psfd_checker_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic rx_dv = 1'b0;
    logic rx_bit = 1'b0;
    logic out_valid, out_bit, frame_start, frame_abort;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    psfd_checker u_psfd_checker (
        .clk(clk), .rst(rst), .enable(enable), .rx_dv(rx_dv), .rx_bit(rx_bit),
        .out_valid(out_valid), .out_bit(out_bit),
        .frame_start(frame_start), .frame_abort(frame_abort)
    );

    task automatic check(input int got, input int exp, input string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 header, 2 forwarding, 3 dropped.
    int   m_mode = 0, m_idx = 0;
    logic m_prev = 1'b0, m_dvq = 1'b1, m_first = 1'b0;
    logic e_v = 1'b0, e_b = 1'b0, e_s = 1'b0, e_a = 1'b0;
    logic model_on = 1'b0;

    always @(posedge clk) begin
        e_v = 1'b0; e_b = 1'b0; e_s = 1'b0; e_a = 1'b0;
        if (rst) begin
            m_mode = 0; m_idx = 0; m_prev = 1'b0; m_dvq = 1'b1; m_first = 1'b0;
        end else begin
            if (!rx_dv || !enable) m_mode = 0;
            else if (m_mode == 0) begin
                if (!m_dvq) begin m_mode = 1; m_idx = 1; end
            end else if (m_mode == 1) begin
                m_idx++;
                if (m_idx >= 18 && m_idx <= 21 && rx_bit == m_prev) begin
                    e_a = 1'b1; m_mode = 3;
                end else if (m_idx >= 22 && rx_bit == m_prev) begin
                    if (rx_bit) begin m_mode = 2; m_first = 1'b1; end
                    else begin e_a = 1'b1; m_mode = 3; end
                end
            end else if (m_mode == 2) begin
                e_v = 1'b1; e_b = rx_bit; e_s = m_first; m_first = 1'b0;
            end
            m_prev = rx_bit;
            m_dvq  = rx_dv;
        end
    end

    int t_start = 0, t_abort = 0, t_fwd = 0;

    always @(negedge clk) begin
        if (model_on) begin
            check(out_valid,   e_v, "R5 out_valid");
            check(out_bit,     e_b, "R5 out_bit");
            check(frame_start, e_s, "R6 frame_start");
            check(frame_abort, e_a, "R7 frame_abort");
        end
        if (frame_start) t_start++;
        if (frame_abort) t_abort++;
        if (out_valid)   t_fwd++;
    end

    logic q[$];

    task automatic push_settle(input logic v);
        for (int i = 0; i < 16; i++) q.push_back(v ^ logic'(i % 3 == 0));
    endtask
    task automatic push_alt(input int n, input logic first);
        for (int i = 0; i < n; i++) q.push_back(first ^ logic'(i % 2));
    endtask
    task automatic push_payload(input int n, input int seed);
        for (int i = 0; i < n; i++) q.push_back(logic'(((i * 7 + seed) >> 1) & 1));
    endtask

    // Drive queued bits; enable forced to en_val from position en_at on (-1: never).
    task automatic send(input int gap, input int en_at, input logic en_val);
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if (i == en_at) enable = en_val;
            rx_dv  = 1'b1;
            rx_bit = q[i];
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            rx_dv = 1'b0; rx_bit = 1'b0;
        end
        q.delete();
    endtask

    task automatic begin_tally();
        @(negedge clk);
        t_start = 0; t_abort = 0; t_fwd = 0;
    endtask
    task automatic end_tally(input int s, input int a, input int f, input string tag);
        repeat (2) @(negedge clk);
        check(t_start, s, {tag, " starts"});
        check(t_abort, a, {tag, " aborts"});
        check(t_fwd,   f, {tag, " forwarded bits"});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(out_valid,   0, "R1 out_valid after reset");
                check(out_bit,     0, "R1 out_bit after reset");
                check(frame_start, 0, "R1 frame_start after reset");
                check(frame_abort, 0, "R1 frame_abort after reset");
                rst = 1'b0; enable = 1'b1;
                model_on = 1'b1;

                // R5 clean header, long hunt (bits 22..27 alternate, 11 at 27/28)
                begin_tally(); push_settle(1'b0); push_alt(5, 1'b1); push_alt(6, 1'b0);
                q.push_back(1'b1); push_payload(10, 3); send(3, -1, 1'b1);
                end_tally(1, 0, 10, "R5 clean header");

                // R5 earliest delimiter at bits 21/22
                begin_tally(); push_settle(1'b1); push_alt(5, 1'b1); q.push_back(1'b1);
                push_payload(8, 5); send(3, -1, 1'b1);
                end_tally(1, 0, 8, "R5 delimiter at bit 22");

                // R3 settling all ones, bit 16 equal to bit 17
                begin_tally();
                for (int i = 0; i < 16; i++) q.push_back(1'b1);
                push_alt(5, 1'b1); push_alt(4, 1'b0); q.push_back(1'b1);
                push_payload(5, 1); send(3, -1, 1'b1);
                end_tally(1, 0, 5, "R3 settle ignored");

                // R4 repeat at bits 18/19
                begin_tally(); push_settle(1'b0); q.push_back(1'b1); q.push_back(1'b0);
                q.push_back(1'b0); push_alt(4, 1'b1); q.push_back(1'b1);
                push_payload(6, 2); send(3, -1, 1'b1);
                end_tally(0, 1, 0, "R4 alternation break");

                // R7 zero pair during hunt, later 11 must be ignored (R8)
                begin_tally(); push_settle(1'b1); push_alt(5, 1'b1); push_alt(4, 1'b0);
                q.push_back(1'b0); q.push_back(1'b0); q.push_back(1'b1); q.push_back(1'b1);
                push_payload(6, 4); send(3, -1, 1'b1);
                end_tally(0, 1, 0, "R7 R8 zero pair in hunt");

                // R7 zero pair at bits 21/22
                begin_tally(); push_settle(1'b0); push_alt(5, 1'b0); q.push_back(1'b0);
                q.push_back(1'b1); q.push_back(1'b1); push_payload(4, 0); send(3, -1, 1'b1);
                end_tally(0, 1, 0, "R7 zero pair at 21/22");

                // R9 data-valid falls during hunt
                begin_tally(); push_settle(1'b0); push_alt(5, 1'b1); push_alt(3, 1'b0);
                send(3, -1, 1'b1);
                end_tally(0, 0, 0, "R9 early end");

                // R10 enable low for the whole frame
                begin_tally(); enable = 1'b0; push_settle(1'b0); push_alt(5, 1'b1);
                q.push_back(1'b1); push_payload(6, 7); send(3, -1, 1'b0);
                end_tally(0, 0, 0, "R10 disabled frame");

                // R2 enable rises at bit 5 of a frame already under way
                begin_tally(); push_settle(1'b0); push_alt(5, 1'b1); q.push_back(1'b1);
                push_payload(6, 6); send(3, 4, 1'b1);
                end_tally(0, 0, 0, "R2 enable mid-frame");

                // R10 enable falls at payload bit 3
                begin_tally(); push_settle(1'b1); push_alt(5, 1'b1); push_alt(6, 1'b0);
                q.push_back(1'b1); push_payload(8, 2); send(3, 31, 1'b0);
                end_tally(1, 0, 3, "R10 enable dropped mid-payload");
                enable = 1'b1;

                // R8 fresh frame after an aborted one, one idle cycle between
                begin_tally(); push_settle(1'b0); q.push_back(1'b0); q.push_back(1'b1);
                q.push_back(1'b1); push_payload(4, 1); send(1, -1, 1'b1);
                push_settle(1'b1); push_alt(5, 1'b1); q.push_back(1'b1);
                push_payload(9, 3); send(3, -1, 1'b1);
                end_tally(1, 1, 9, "R8 rearm after abort");
            end
            begin
                repeat (20000) @(negedge clk);
                check(0, 1, "watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule